// File: doc/BRIEF.md
# Multi-Phase Sampling Time-to-Digital Converter

This block assigns a fine-grained arrival time to each rising edge of a single pulse input and reports how long it has been since the previous edge. The input is sampled by one flop on each of several evenly spaced phases of the system clock. With four phases of a 250 MHz clock, the sample instants are 1 ns apart. Those samples are moved into the phase-0 domain as one word per clock cycle. An encoder finds the earliest sample in that word that reads high after a low one. The bit-index of that sample is the fine time, and it is appended below a free-running coarse cycle counter to form a timestamp.

The main use is reading out a recycling current-to-frequency converter. Each output pulse of that converter stands for a fixed charge, so the current is that charge divided by the interval between pulses. The block therefore gives the interval directly, computed modulo the timestamp width so that counter wrap does no harm. A wide pulse counts once. The first edge after reset has no predecessor, so it yields a timestamp without an interval.

Top module: `mpt_tdc`

## Requirements
- R1: After reset, `stamp_vld_o` and `gap_vld_o` are low until a rising edge has been seen on `pulse_i`.
- R2: Phase p of `clk_ph_i` (p = 0 to NPH-1) samples at p/NPH of a period after the phase-0 rising edge. The low `$clog2(NPH)` bits of `stamp_o` hold the index p of the earliest sample instant at which the input reads high.
- R3: For two edges, the difference of their timestamps, modulo 2^`TS_W`, equals the number of sample instants between their first high samples. One count is one sample spacing (1 ns at 250 MHz with four phases).
- R4: A pulse whose high and low phases each last at least two clock periods produces exactly one `stamp_vld_o` strobe, one cycle wide, however long it stays high.
- R5: The first timestamp after reset comes with `gap_vld_o` low. Every later timestamp comes with `gap_vld_o` high.
- R6: `gap_o` equals the current timestamp minus the previous one, modulo 2^`TS_W`. This stays correct when the coarse counter wraps between the two edges.
- R7: If the input is already high when reset is released, no timestamp is produced until the input has been seen low and then rises again.
- R8: An edge whose first high sample is phase 0 is detected by comparing that sample with the last-phase sample of the previous cycle. Such an edge is stamped with fine code 0.
- R9: `gap_vld_o` is never high in a cycle where `stamp_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph_i | input | NPH | Evenly spaced clock phases; bit 0 is the system clock for all outputs |
| rst_ni | input | 1 | Active-low reset, synchronous to phase 0 |
| pulse_i | input | 1 | Pulse input whose rising edges are time-stamped |
| stamp_o | output | COARSE_W+$clog2(NPH) | Timestamp: coarse count above fine phase index |
| stamp_vld_o | output | 1 | One-cycle strobe marking a new timestamp |
| gap_o | output | COARSE_W+$clog2(NPH) | Time since the previous timestamp, in sample spacings |
| gap_vld_o | output | 1 | Marks `gap_o` as meaningful for this timestamp |

## Verification
The bench builds the block with NPH = 4, SYNC_DEPTH = 2 and COARSE_W = 8. The two-stage resynchronising chain is therefore the variant under test. The timestamp wraps every 1024 ns, so a few pulses several hundred nanoseconds apart cross the wrap more than once, which tests the modular interval. Pulse edges are placed half a nanosecond off each sample instant. This makes the expected fine code and interval exact integers. A sweep of edges 101 ns apart steps the fine code through all four phases, including the case where a phase-0 sample is compared with the previous cycle's last-phase sample.

// File: rtl/mpt_pkg.sv
`timescale 1ns/1ps
package mpt_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mpt_phase_capture.sv
`timescale 1ns/1ps
module mpt_phase_capture #(
   parameter int unsigned NPH        = 4,
   parameter int unsigned SYNC_DEPTH = 1
) (
   input  logic [NPH-1:0] clk_ph_i,
   input  logic           rst_ni,
   input  logic           pulse_i,
   output logic [NPH-1:0] word_o
);

   logic [NPH-1:0]              raw_w;
   logic [SYNC_DEPTH:0][NPH-1:0] chain_q;

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      logic smp_q;
      always_ff @(posedge clk_ph_i[p]) begin
         smp_q <= pulse_i;
      end
      assign raw_w[p] = smp_q;
   end

   assign chain_q[0] = raw_w;

   for (genvar d = 0; d < SYNC_DEPTH; d++) begin : g_sync
      always_ff @(posedge clk_ph_i[0]) begin
         if (!rst_ni) chain_q[d+1] <= '1;
         else         chain_q[d+1] <= chain_q[d];
      end
   end

   assign word_o = chain_q[SYNC_DEPTH];

endmodule

// File: rtl/mpt_edge_encoder.sv
`timescale 1ns/1ps
module mpt_edge_encoder #(
   parameter int unsigned NPH    = 4,
   parameter int unsigned FINE_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPH-1:0]    word_i,
   output logic              hit_o,
   output logic [FINE_W-1:0] fine_o
);

   logic              prev_q;
   logic [NPH-1:0]    rise_w;
   logic              found_w;
   logic [FINE_W-1:0] fine_w;

   always_comb begin
      rise_w[0] = word_i[0] & ~prev_q;
      for (int i = 1; i < NPH; i++) begin
         rise_w[i] = word_i[i] & ~word_i[i-1];
      end
   end

   always_comb begin
      found_w = 1'b0;
      fine_w  = '0;
      for (int i = 0; i < NPH; i++) begin
         if (rise_w[i] && !found_w) begin
            found_w = 1'b1;
            fine_w  = FINE_W'(i);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
         hit_o  <= 1'b0;
         fine_o <= '0;
      end else begin
         prev_q <= word_i[NPH-1];
         hit_o  <= found_w;
         fine_o <= fine_w;
      end
   end

endmodule

// File: rtl/mpt_stamp_unit.sv
`timescale 1ns/1ps
module mpt_stamp_unit #(
   parameter int unsigned COARSE_W = 24,
   parameter int unsigned FINE_W   = 2
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       hit_i,
   input  logic [FINE_W-1:0]          fine_i,
   output logic [COARSE_W+FINE_W-1:0] stamp_o,
   output logic                       stamp_vld_o,
   output logic [COARSE_W+FINE_W-1:0] gap_o,
   output logic                       gap_vld_o
);

   localparam int unsigned TS_W = COARSE_W + FINE_W;

   logic [COARSE_W-1:0] coarse_q;
   logic [TS_W-1:0]     last_q;
   logic                have_q;
   logic [TS_W-1:0]     now_w;

   assign now_w = {coarse_q, fine_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         coarse_q    <= '0;
         last_q      <= '0;
         have_q      <= 1'b0;
         stamp_o     <= '0;
         stamp_vld_o <= 1'b0;
         gap_o       <= '0;
         gap_vld_o   <= 1'b0;
      end else begin
         coarse_q    <= coarse_q + 1'b1;
         stamp_vld_o <= hit_i;
         gap_vld_o   <= hit_i & have_q;
         if (hit_i) begin
            stamp_o <= now_w;
            gap_o   <= now_w - last_q;
            last_q  <= now_w;
            have_q  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mpt_tdc.sv
`timescale 1ns/1ps
module mpt_tdc #(
   parameter int unsigned NPH        = 4,
   parameter int unsigned COARSE_W   = 24,
   parameter int unsigned SYNC_DEPTH = 1
) (
   input  logic [NPH-1:0]                     clk_ph_i,
   input  logic                               rst_ni,
   input  logic                               pulse_i,
   output logic [COARSE_W+$clog2(NPH)-1:0]    stamp_o,
   output logic                               stamp_vld_o,
   output logic [COARSE_W+$clog2(NPH)-1:0]    gap_o,
   output logic                               gap_vld_o
);

   localparam int unsigned FINE_W = mpt_pkg::idx_bits(NPH);
   localparam int unsigned TS_W   = COARSE_W + FINE_W;

   initial begin
      assert (NPH >= 2 && mpt_pkg::is_pow2(NPH))
         else $error("NPH must be a power of two of at least 2");
      assert (SYNC_DEPTH >= 1)
         else $error("SYNC_DEPTH must be at least 1");
      assert (COARSE_W >= 2)
         else $error("COARSE_W must be at least 2");
   end

   logic [NPH-1:0]    word_w;
   logic              hit_w;
   logic [FINE_W-1:0] fine_w;

   mpt_phase_capture #(.NPH(NPH), .SYNC_DEPTH(SYNC_DEPTH)) u_cap (
      .clk_ph_i (clk_ph_i),
      .rst_ni   (rst_ni),
      .pulse_i  (pulse_i),
      .word_o   (word_w)
   );

   mpt_edge_encoder #(.NPH(NPH), .FINE_W(FINE_W)) u_enc (
      .clk_i  (clk_ph_i[0]),
      .rst_ni (rst_ni),
      .word_i (word_w),
      .hit_o  (hit_w),
      .fine_o (fine_w)
   );

   mpt_stamp_unit #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_stamp (
      .clk_i       (clk_ph_i[0]),
      .rst_ni      (rst_ni),
      .hit_i       (hit_w),
      .fine_i      (fine_w),
      .stamp_o     (stamp_o),
      .stamp_vld_o (stamp_vld_o),
      .gap_o       (gap_o),
      .gap_vld_o   (gap_vld_o)
   );

endmodule

// File: rtl/mpt_tdc_sva.sv
`timescale 1ns/1ps
module mpt_tdc_sva #(
   parameter int unsigned TS_W = 26
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [TS_W-1:0] stamp_i,
   input logic            stamp_vld_i,
   input logic [TS_W-1:0] gap_i,
   input logic            gap_vld_i
);

   logic [TS_W-1:0] seen_last_q;
   logic            seen_any_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         seen_last_q <= '0;
         seen_any_q  <= 1'b0;
      end else if (stamp_vld_i) begin
         seen_last_q <= stamp_i;
         seen_any_q  <= 1'b1;
      end
   end

   AST_GAP_NEEDS_STAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_vld_i |-> stamp_vld_i); // R9

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stamp_vld_i |=> !stamp_vld_i); // R4

   AST_FIRST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stamp_vld_i && !seen_any_q) |-> !gap_vld_i); // R5

   AST_LATER_HAS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stamp_vld_i && seen_any_q) |-> gap_vld_i); // R5

   AST_GAP_MODULAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_vld_i |-> (gap_i == TS_W'(stamp_i - seen_last_q))); // R6

endmodule

bind mpt_tdc mpt_tdc_sva #(.TS_W($bits(stamp_o))) u_sva (
   .clk_i       (clk_ph_i[0]),
   .rst_ni      (rst_ni),
   .stamp_i     (stamp_o),
   .stamp_vld_i (stamp_vld_o),
   .gap_i       (gap_o),
   .gap_vld_i   (gap_vld_o)
);

// File: tb/tb_mpt_tdc.sv
`timescale 1ns/1ps
module tb_mpt_tdc;

   localparam int CLK_NS   = 4;
   localparam int NPH      = 4;
   localparam int COARSE_W = 8;
   localparam int TS_W     = COARSE_W + 2;
   localparam int MODV     = 1 << TS_W;

   logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
   logic [NPH-1:0] clk_ph;
   logic rst_n = 1'b0;
   logic pulse = 1'b0;
   logic [TS_W-1:0] stamp, gap;
   logic stamp_vld, gap_vld;

   assign clk_ph = {c3, c2, c1, c0};

   always #(CLK_NS/2) c0 = ~c0;
   initial begin #1; forever #(CLK_NS/2) c1 = ~c1; end
   initial begin #2; forever #(CLK_NS/2) c2 = ~c2; end
   initial begin #3; forever #(CLK_NS/2) c3 = ~c3; end

   mpt_tdc #(.NPH(NPH), .COARSE_W(COARSE_W), .SYNC_DEPTH(2)) dut (
      .clk_ph_i    (clk_ph),
      .rst_ni      (rst_n),
      .pulse_i     (pulse),
      .stamp_o     (stamp),
      .stamp_vld_o (stamp_vld),
      .gap_o       (gap),
      .gap_vld_o   (gap_vld)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int ev_n = 0;
   int orphan = 0;
   int ev_ts [64];
   int ev_gap [64];
   bit ev_gv [64];

   always @(negedge c0) begin
      if (rst_n) begin
         if (gap_vld && !stamp_vld) orphan++;
         if (stamp_vld && ev_n < 64) begin
            ev_ts[ev_n]  = int'(stamp);
            ev_gap[ev_n] = int'(gap);
            ev_gv[ev_n]  = gap_vld;
            ev_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge c0);
   endtask

   task automatic do_reset();
      @(negedge c0);
      rst_n = 1'b0;
      cycles(5);
      rst_n = 1'b1;
      ev_n = 0;
   endtask

   // Rising edge at n+0.5 ns; first high sample at n+1, phase index (n+1-2) mod 4.
   task automatic pulse_at(input int n, input int width);
      #((real'(n) + 0.5) - $realtime);
      pulse = 1'b1;
      #(width);
      pulse = 1'b0;
   endtask

   function automatic int exp_fine(input int n);
      return (n + 3) % 4;
   endfunction

   function automatic int now_ns();
      return int'($realtime);
   endfunction

   task automatic t_reset();
      do_reset();
      cycles(3);
      chk(stamp_vld == 1'b0, "R1 stamp_vld after reset", stamp_vld, 0);
      chk(gap_vld == 1'b0, "R1 gap_vld after reset", gap_vld, 0);
   endtask

   task automatic t_first();
      int n;
      do_reset();
      n = now_ns() + 21;
      pulse_at(n, 60);
      cycles(20);
      chk(ev_n == 1, "R4 one stamp for one pulse", ev_n, 1);
      chk(ev_gv[0] == 1'b0, "R5 first stamp without gap", ev_gv[0], 0);
      chk((ev_ts[0] & 3) == exp_fine(n), "R2 fine code", ev_ts[0] & 3, exp_fine(n));
   endtask

   task automatic t_sweep();
      int base;
      int ns [4];
      do_reset();
      base = now_ns() + 20;
      for (int k = 0; k < 4; k++) ns[k] = base + 101 * k;
      for (int k = 0; k < 4; k++) pulse_at(ns[k], 40);
      cycles(20);
      chk(ev_n == 4, "R4 sweep stamp count", ev_n, 4);
      for (int k = 0; k < 4; k++) begin
         chk((ev_ts[k] & 3) == exp_fine(ns[k]), "R2 sweep fine code", ev_ts[k] & 3, exp_fine(ns[k]));
         if (exp_fine(ns[k]) == 0)
            chk((ev_ts[k] & 3) == 0, "R8 edge after last phase coded 0", ev_ts[k] & 3, 0);
      end
      for (int k = 1; k < 4; k++) begin
         chk(((ev_ts[k] - ev_ts[k-1]) % MODV + MODV) % MODV == 101,
             "R3 stamp difference", ((ev_ts[k] - ev_ts[k-1]) % MODV + MODV) % MODV, 101);
         chk(ev_gv[k] == 1'b1, "R5 later stamp has gap", ev_gv[k], 1);
         chk(ev_gap[k] == 101, "R6 gap value", ev_gap[k], 101);
      end
   endtask

   task automatic t_wide();
      int n;
      do_reset();
      n = now_ns() + 22;
      pulse_at(n, 300);
      cycles(20);
      chk(ev_n == 1, "R4 wide pulse counted once", ev_n, 1);
   endtask

   task automatic t_armed();
      int n;
      pulse = 1'b1;
      do_reset();
      cycles(30);
      chk(ev_n == 0, "R7 no stamp while high from reset", ev_n, 0);
      chk(stamp_vld == 1'b0, "R7 stamp_vld low while high", stamp_vld, 0);
      pulse = 1'b0;
      cycles(10);
      chk(ev_n == 0, "R7 no stamp on falling edge", ev_n, 0);
      n = now_ns() + 23;
      pulse_at(n, 50);
      cycles(20);
      chk(ev_n == 1, "R7 stamp after seen low", ev_n, 1);
      chk(ev_gv[0] == 1'b0, "R5 no gap on first after reset", ev_gv[0], 0);
   endtask

   task automatic t_wrap();
      int ns [4];
      int sp [4];
      do_reset();
      sp[0] = 0; sp[1] = 700; sp[2] = 650; sp[3] = 900;
      ns[0] = now_ns() + 20;
      for (int k = 1; k < 4; k++) ns[k] = ns[k-1] + sp[k];
      for (int k = 0; k < 4; k++) pulse_at(ns[k], 80);
      cycles(20);
      chk(ev_n == 4, "R6 wrap stamp count", ev_n, 4);
      for (int k = 1; k < 4; k++) begin
         chk(ev_gv[k] == 1'b1, "R5 wrap gap valid", ev_gv[k], 1);
         chk(ev_gap[k] == sp[k], "R6 gap across wrap", ev_gap[k], sp[k]);
      end
      chk(orphan == 0, "R9 gap_vld without stamp_vld", orphan, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge c0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      t_reset();
      t_first();
      t_sweep();
      t_wide();
      t_armed();
      t_wrap();
      summary();
   end

endmodule